// File: doc/BRIEF.md
# External Interrupt Pin Sense Channel

This block watches a set of external interrupt pins and turns a selected condition on each one into a sticky flag. Each pin passes through a two-stage synchronizer. A per-pin enable can then route it through a three-sample majority-vote filter. The synchronized or filtered value goes to a detector. The detector recognises a rising edge, a falling edge, either edge, a high level or a low level, chosen by a 3-bit code per pin. When the chosen condition holds, the pin's flag is set. Software removes flags by writing ones to a clear mask. A single interrupt line is raised while any flag whose enable bit is set remains set.

A strobe input, `sample_stb`, stands in for the slow detection clock. The filter shifts only on strobe cycles, and edges are judged only on strobe cycles. An unfiltered level condition is judged on every system clock. The behaviour on a clear depends on the mode. In edge mode a cleared flag stays clear until a fresh edge arrives. In level mode the flag comes back at once if the pin still shows the active level.

Top module: `ext_irq_sense`

## Requirements
- R1: Sense code 1 sets the pin's flag on a 0-to-1 transition, code 2 sets it on a 1-to-0 transition, and code 3 sets it on either transition.
- R2: Sense code 4 sets the flag while the pin is 1, and code 5 sets it while the pin is 0. While the level persists, a clear does not leave the flag at 0.
- R3: Sense codes 0, 6 and 7 never set the flag, whatever the pin does.
- R4: In an edge mode, a flag that has been cleared stays 0 while the pin holds its level. Only a new transition sets it again.
- R5: On a cycle with `clr_wr` high, each flag whose bit in `clr_mask` is 1 goes to 0, and flags whose bit is 0 are kept. If a set condition and a clear hit the same pin in the same cycle, the flag ends at 1.
- R6: With `filt_en` set for a pin, the detector sees the majority of the last three strobe samples. A pulse seen on only one sample is rejected, and one seen on two samples is accepted.
- R7: With the strobe high on every cycle, an unfiltered condition reaches the flag on the third clock after the pin changes. A filtered condition reaches it on the fifth clock.
- R8: Edge conditions are evaluated only in cycles with `sample_stb` high. An unfiltered level condition is evaluated on every clock, regardless of the strobe.
- R9: `irq` is a register equal to the OR over pins of flag AND `irq_en`, updated in the same clock as the flags.
- R10: Synchronous reset clears all flags and `irq`. It also loads the edge reference and the filter window from the current pin value, so a pin held high through reset reports no edge afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Detection sample strobe (slow clock enable) |
| pin_in | input | PINS | Raw external pin levels |
| sense_cfg | input | 3*PINS | Per-pin sense code, pin p at bits [3p+2:3p] |
| filt_en | input | PINS | Per-pin majority filter enable |
| irq_en | input | PINS | Per-pin interrupt enable |
| clr_wr | input | 1 | Clear strobe for flags |
| clr_mask | input | PINS | Write-one-to-clear mask, used when clr_wr is high |
| flags | output | PINS | Sticky per-pin interrupt flags |
| irq | output | 1 | Combined interrupt request |

## Verification
Single-transition stimuli in each direction tell the three edge codes apart, and they also confirm that the inactive direction is ignored. Holding a level across a clear separates edge behaviour, where the flag stays clear, from level behaviour, where it comes back. One-cycle and two-cycle pulses on a filtered pin show the majority threshold. The exact cycle in which the flag appears separates the filtered path from the unfiltered one. A run with the strobe held low shows that edges wait for the strobe while unfiltered levels do not. The same run uses a masked enable to show that `irq` follows only enabled flags.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int SENSE_W = 3;
  localparam logic [SENSE_W-1:0] SNS_OFF  = 3'd0;
  localparam logic [SENSE_W-1:0] SNS_RISE = 3'd1;
  localparam logic [SENSE_W-1:0] SNS_FALL = 3'd2;
  localparam logic [SENSE_W-1:0] SNS_BOTH = 3'd3;
  localparam logic [SENSE_W-1:0] SNS_HIGH = 3'd4;
  localparam logic [SENSE_W-1:0] SNS_LOW  = 3'd5;

  function automatic logic sense_is_edge(input logic [SENSE_W-1:0] code);
    return (code == SNS_RISE) || (code == SNS_FALL) || (code == SNS_BOTH);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{din}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/maj_filter.sv
module maj_filter #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic seed,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam int HALF  = TAPS / 2;

  logic [TAPS-1:0]  window;
  logic [CNT_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst)      window <= {TAPS{seed}};
    else if (stb) window <= {window[TAPS-2:0], din};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CNT_W'(window[i]);
  end

  assign dout = (ones > CNT_W'(HALF));
endmodule

// File: rtl/sense_detect.sv
module sense_detect
  import eic_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic               seed,
  input  logic               lvl,
  input  logic [SENSE_W-1:0] sense,
  output logic               hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst)      prev <= seed;
    else if (stb) prev <= lvl;
  end

  always_comb begin
    unique case (sense)
      SNS_RISE: hit = stb & lvl & ~prev;
      SNS_FALL: hit = stb & ~lvl & prev;
      SNS_BOTH: hit = stb & (lvl ^ prev);
      SNS_HIGH: hit = lvl;
      SNS_LOW:  hit = ~lvl;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eic_pkg::*;
#(
  parameter int PINS        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_stb,
  input  logic [PINS-1:0]      pin_in,
  input  logic [PINS*3-1:0]    sense_cfg,
  input  logic [PINS-1:0]      filt_en,
  input  logic [PINS-1:0]      irq_en,
  input  logic                 clr_wr,
  input  logic [PINS-1:0]      clr_mask,
  output logic [PINS-1:0]      flags,
  output logic                 irq
);
  logic [PINS-1:0] sync_v;
  logic [PINS-1:0] filt_v;
  logic [PINS-1:0] lvl_v;
  logic [PINS-1:0] hit_v;
  logic [PINS-1:0] clr_v;
  logic [PINS-1:0] flags_nxt;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_in[p]),
      .dout (sync_v[p])
    );

    maj_filter #(.TAPS(FILT_TAPS)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .stb  (sample_stb),
      .seed (pin_in[p]),
      .din  (sync_v[p]),
      .dout (filt_v[p])
    );

    assign lvl_v[p] = filt_en[p] ? filt_v[p] : sync_v[p];

    sense_detect u_det (
      .clk   (clk),
      .rst   (rst),
      .stb   (sample_stb),
      .seed  (pin_in[p]),
      .lvl   (lvl_v[p]),
      .sense (sense_cfg[p*SENSE_W +: SENSE_W]),
      .hit   (hit_v[p])
    );
  end

  assign clr_v     = {PINS{clr_wr}} & clr_mask;
  assign flags_nxt = hit_v | (flags & ~clr_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |(flags_nxt & irq_en);
    end
  end
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import eic_pkg::*;
#(
  parameter int PINS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_stb,
  input logic [PINS-1:0]   pin_in,
  input logic [PINS*3-1:0] sense_cfg,
  input logic [PINS-1:0]   filt_en,
  input logic [PINS-1:0]   irq_en,
  input logic              clr_wr,
  input logic [PINS-1:0]   clr_mask,
  input logic [PINS-1:0]   flags,
  input logic              irq
);
  p_reset_clean_r10: assert property (@(posedge clk)
    rst |=> (flags == '0 && !irq));

  p_irq_tracks_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(flags & $past(irq_en))));

  for (genvar p = 0; p < PINS; p++) begin : g_chk
    logic [SENSE_W-1:0] sc;
    logic               sc_off;
    logic               sc_edge;
    assign sc      = sense_cfg[p*SENSE_W +: SENSE_W];
    assign sc_off  = (sc == SNS_OFF) || (sc > SNS_LOW);
    assign sc_edge = sense_is_edge(sc);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (flags[p] && !(clr_wr && clr_mask[p])) |=> flags[p]);

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (sc_off && !flags[p]) |=> !flags[p]);

    p_edge_needs_strobe_r8: assert property (@(posedge clk) disable iff (rst)
      (sc_edge && !sample_stb && !flags[p]) |=> !flags[p]);

    p_edge_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (sc_edge && !sample_stb && clr_wr && clr_mask[p]) |=> !flags[p]);
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  localparam int PINS = 4;
  localparam logic [PINS-1:0] P0 = 4'b0001, P1 = 4'b0010, P2 = 4'b0100, P3 = 4'b1000;
  localparam logic [PINS-1:0] ALL = 4'b1111;

  logic              clk = 1'b0;
  logic              rst;
  logic              sample_stb;
  logic [PINS-1:0]   pin_in;
  logic [PINS*3-1:0] sense_cfg;
  logic [PINS-1:0]   filt_en;
  logic [PINS-1:0]   irq_en;
  logic              clr_wr;
  logic [PINS-1:0]   clr_mask;
  logic [PINS-1:0]   flags;
  logic              irq;

  always #10 clk = ~clk;

  ext_irq_sense #(.PINS(PINS)) dut (.*);

  typedef struct {
    int              at;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] val;
    bit              is_irq;
    logic            irqv;
    string           tag;
  } item_t;

  item_t q[$];
  int    cyc    = 0;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop every expectation due in this cycle and compare.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        n_chk++;
        if (q[i].is_irq) begin
          if (irq !== q[i].irqv) begin
            n_fail++;
            $display("FAIL %s: irq actual=%b expected=%b (cycle %0d)", q[i].tag, irq, q[i].irqv, cyc);
          end
        end else if ((flags & q[i].mask) !== (q[i].val & q[i].mask)) begin
          n_fail++;
          $display("FAIL %s: flags actual=%b expected=%b mask=%b (cycle %0d)",
                   q[i].tag, flags, q[i].val, q[i].mask, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic expf(input int d, input logic [PINS-1:0] m, input logic [PINS-1:0] v, input string tag);
    item_t it;
    it.at = cyc + d; it.mask = m; it.val = v; it.is_irq = 0; it.irqv = 1'b0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expi(input int d, input logic v, input string tag);
    item_t it;
    it.at = cyc + d; it.mask = '0; it.val = '0; it.is_irq = 1; it.irqv = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sense(input int p, input logic [2:0] code);
    sense_cfg[p*3 +: 3] = code;
  endtask

  task automatic clear(input logic [PINS-1:0] m);
    clr_wr = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    report();
  end

  initial begin
    rst = 1'b1; sample_stb = 1'b1; pin_in = P0; sense_cfg = '0; filt_en = '0;
    irq_en = ALL; clr_wr = 1'b0; clr_mask = '0;
    set_sense(0, 3'd1);
    expf(1, ALL, '0, "R10 reset state flags");
    expi(1, 1'b0, "R10 reset state irq");
    wait_n(4);
    rst = 1'b0;
    // R10: pin 0 high through reset with rise sense gives no edge
    for (int d = 1; d <= 6; d++) begin
      expf(d, ALL, '0, "R10 no spurious edge");
      expi(d, 1'b0, "R10 irq idle");
    end
    wait_n(7);

    // R1 rise / R7 latency
    pin_in[0] = 1'b0;
    for (int d = 1; d <= 5; d++) expf(d, P0, '0, "R1 rise ignores fall");
    wait_n(6);
    pin_in[0] = 1'b1;
    expf(2, P0, '0, "R7 unfiltered not early");
    expf(3, P0, P0, "R1 rise sets flag");
    expi(2, 1'b0, "R9 irq not early");
    expi(3, 1'b1, "R9 irq with flag");
    wait_n(6);

    // R4: clear while pin stays high
    for (int d = 1; d <= 6; d++) expf(d, P0, '0, "R4 edge stays clear");
    expi(1, 1'b0, "R9 irq drops");
    clear(P0);
    wait_n(6);

    // R1 fall
    set_sense(1, 3'd2);
    pin_in[1] = 1'b1;
    for (int d = 1; d <= 6; d++) expf(d, P1, '0, "R1 fall ignores rise");
    wait_n(7);
    pin_in[1] = 1'b0;
    expf(2, P1, '0, "R7 fall not early");
    expf(3, P1, P1, "R1 fall sets flag");
    wait_n(5);
    clear(P1);
    wait_n(2);

    // R1 both edges
    set_sense(2, 3'd3);
    pin_in[2] = 1'b1;
    expf(3, P2, P2, "R1 both on rise");
    wait_n(5);
    expf(1, P2, '0, "R5 clear drops flag");
    clear(P2);
    wait_n(3);
    pin_in[2] = 1'b0;
    expf(3, P2, P2, "R1 both on fall");
    wait_n(5);
    expf(1, ALL, '0, "R5 clear only masked");
    clear(P2);
    wait_n(3);

    // R2 high level, re-assert on clear
    set_sense(3, 3'd4);
    pin_in[3] = 1'b1;
    expf(2, P3, '0, "R7 level not early");
    expf(3, P3, P3, "R2 high sets flag");
    wait_n(5);
    expf(1, P3, P3, "R2 level reasserts");
    expf(3, P3, P3, "R2 level stays set");
    clear(P3);
    wait_n(4);
    pin_in[3] = 1'b0;
    wait_n(5);
    expf(1, P3, '0, "R5 clear after level gone");
    expf(4, P3, '0, "R2 no high once low");
    clear(P3);
    wait_n(5);

    // R2 low level
    set_sense(3, 3'd5);
    expf(1, P3, P3, "R2 low sets flag");
    wait_n(3);
    pin_in[3] = 1'b1;
    wait_n(5);
    expf(1, P3, '0, "R2 low released then cleared");
    clear(P3);
    wait_n(3);

    // R3 codes 0, 6, 7
    set_sense(0, 3'd0); set_sense(1, 3'd6); set_sense(2, 3'd7); set_sense(3, 3'd0);
    for (int d = 1; d <= 12; d++) expf(d, ALL, '0, "R3 inactive codes");
    pin_in = 4'b0110;
    wait_n(3);
    pin_in = 4'b1001;
    wait_n(3);
    pin_in = 4'b0000;
    wait_n(7);

    // R6 filter: one-sample glitch rejected
    filt_en[1] = 1'b1;
    set_sense(1, 3'd1);
    wait_n(1);
    pin_in[1] = 1'b1;
    for (int d = 1; d <= 10; d++) expf(d, P1, '0, "R6 glitch rejected");
    wait_n(1);
    pin_in[1] = 1'b0;
    wait_n(10);
    // two-sample pulse accepted, five-cycle latency
    pin_in[1] = 1'b1;
    expf(4, P1, '0, "R7 filtered edge not early");
    expf(5, P1, P1, "R6 two samples accepted");
    wait_n(2);
    pin_in[1] = 1'b0;
    wait_n(6);
    expf(1, P1, '0, "R5 clear filtered");
    clear(P1);
    wait_n(4);

    // R7 filtered level
    set_sense(1, 3'd4);
    pin_in[1] = 1'b1;
    expf(4, P1, '0, "R7 filtered level not early");
    expf(5, P1, P1, "R7 filtered level latency");
    wait_n(6);
    pin_in[1] = 1'b0;
    wait_n(8);
    expf(1, P1, '0, "R5 clear filtered level");
    clear(P1);
    wait_n(2);
    set_sense(1, 3'd0);
    filt_en = '0;
    wait_n(4);

    // R8 strobe gating, R9 masking
    irq_en = P0;
    set_sense(0, 3'd1);
    set_sense(3, 3'd4);
    wait_n(4);
    sample_stb = 1'b0;
    pin_in[0] = 1'b1;
    pin_in[3] = 1'b1;
    for (int d = 1; d <= 8; d++) expf(d, P0, '0, "R8 edge waits for strobe");
    expf(3, P3, P3, "R8 level without strobe");
    for (int d = 3; d <= 8; d++) expi(d, 1'b0, "R9 masked flag no irq");
    wait_n(8);
    sample_stb = 1'b1;
    expf(1, P0, P0, "R8 edge on strobe");
    expi(1, 1'b1, "R9 enabled flag irq");
    wait_n(1);
    sample_stb = 1'b0;
    wait_n(2);
    sample_stb = 1'b1;
    set_sense(3, 3'd0);
    expf(1, P0 | P3, '0, "R5 clear two flags");
    expi(1, 1'b0, "R9 irq clears");
    clear(P0 | P3);
    irq_en = ALL;
    wait_n(3);

    // R5 set wins over clear in the same cycle
    set_sense(2, 3'd1);
    wait_n(3);
    pin_in[2] = 1'b1;
    expf(3, P2, P2, "R5 set wins over clear");
    wait_n(2);
    clr_wr = 1'b1; clr_mask = P2;
    wait_n(1);
    clr_wr = 1'b0; clr_mask = '0;
    wait_n(4);

    wait_n(3);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", q.size());
    end
    report();
  end
endmodule